// File: doc/BRIEF.md
# Wheel Rotation Pulse Rate Counter

This block measures how fast a drive sprocket or motor shaft turns by counting the pulses that a rotation sensor (a Hall-effect transducer or a slotted photo-interrupter) produces during a fixed sample window. The raw sensor line is not used as a clock. It is brought into the system clock domain through a synchronising shift register, and each rising edge detected there adds one to a running count.

A window timer counts system clock cycles. When a window ends, the running count moves into a holding register that software reads, and the counter restarts from zero on the same edge. The result is pulses per window rather than a free-running total. Software can multiply it by a distance-per-pulse constant elsewhere. A one-cycle strobe and a sticky ready flag announce each new sample, and a read acknowledge clears the flag. If the count saturates within a window, an overflow flag is stored with the sample.

The window length comes from an input in clock cycles. The value zero selects a build-time default of 50,000,000 cycles, which is 500 ms at 100 MHz. The sample width defaults to 32 bits so that it fits a 32-bit processor data bus.

Top module: `wheel_pulse_meter`

## Requirements
- R1: While `rst_n` is low at a clock edge, `sample_cnt`, `sample_ovf`, `sample_stb` and `sample_rdy` are all 0 after that edge.
- R2: The sensor passes through a two-stage synchroniser. A low-to-high change held for two cycles is counted once, at the second clock edge after the first edge that samples it high. A level held high for any length adds only one count.
- R3: At every window end, `sample_cnt` takes the number of pulses counted in that window and the running count restarts. Between window ends, `sample_cnt` does not change.
- R4: A window lasts `win_len` system clock cycles. The first capture happens at the `win_len`-th rising clock edge after reset is released, and each later capture follows `win_len` edges after the one before it. `win_len` = 0 selects `DEF_WIN_CYC` cycles.
- R5: A pulse counted on the same edge as a window capture belongs to the following window. It is neither lost nor counted twice.
- R6: `sample_stb` is high for exactly the one cycle that follows each capture edge when the window is longer than one cycle.
- R7: `sample_rdy` is set by each capture and stays set until a cycle with `rd_ack` high. If a capture and `rd_ack` fall on the same edge, the flag stays set. `rd_ack` leaves `sample_cnt` unchanged.
- R8: The running count saturates at 2^CNT_W-1. A pulse arriving at that value sets an overflow marker, which is stored as `sample_ovf` with that window's sample. When `sample_ovf` is 1, `sample_cnt` is all ones. The marker is cleared for the next window.
- R9: A window with exactly 2^CNT_W-1 pulses reports that count with `sample_ovf` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sens_in | input | 1 | Raw rotation sensor pulse, asynchronous |
| win_len | input | WIN_W (32) | Window length in clock cycles, 0 selects the default |
| rd_ack | input | 1 | Read acknowledge, clears the ready flag |
| sample_cnt | output | CNT_W (32) | Pulse count captured at the last window end |
| sample_ovf | output | 1 | The captured window saturated |
| sample_stb | output | 1 | One-cycle pulse after each capture |
| sample_rdy | output | 1 | Sticky flag for an unread sample |

## Verification
The bench counts rising clock edges from the release of reset and schedules every stimulus against that count. Under R4 a capture lands on edge `win_len`, so the sample, the strobe and the ready flag are checked in the half cycle after that edge, and the strobe is also checked low on the edge before it and the edge after it. A sensor change set up before edge d is counted on edge d+2. Pulses are therefore placed so that their counting edge falls a known distance from a window end, including exactly on it for R5. A read acknowledge takes effect on the next edge, and the ready flag is checked one edge after the acknowledge is driven.

// File: rtl/wpm_pkg.sv
// Shared build-time defaults for the wheel pulse rate counter.
// Assumes: all users take their parameter defaults from here.
package wpm_pkg;
    localparam int unsigned CNT_W_DEF       = 32;
    localparam int unsigned WIN_W_DEF       = 32;
    localparam int unsigned SYNC_STAGES_DEF = 2;
    localparam int unsigned DEF_WIN_CYC_DEF = 50_000_000; // 500 ms at 100 MHz
endpackage

// File: rtl/wpm_edge_sync.sv
// Brings the asynchronous sensor line into the clock domain and flags
// each rising edge for one cycle.
// Assumes: STAGES >= 2 and sensor pulses last at least two clock cycles.
module wpm_edge_sync #(
    parameter int unsigned STAGES = wpm_pkg::SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Shift the raw level through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], din};
        end
    end

    // Remember the synchronised level from the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
        end else begin
            last_q <= sync_q[STAGES-1];
        end
    end

    // The level is high now and was low one cycle earlier.
    always_comb begin
        rise = sync_q[STAGES-1] & ~last_q;
    end
endmodule

// File: rtl/wpm_win_timer.sv
// Counts clock cycles and raises tick in the last cycle of each window.
// The timer restarts at once after each window ends.
// Assumes: DEF_WIN_CYC >= 1. A win_len of 0 selects DEF_WIN_CYC.
module wpm_win_timer #(
    parameter int unsigned WIN_W       = wpm_pkg::WIN_W_DEF,
    parameter int unsigned DEF_WIN_CYC = wpm_pkg::DEF_WIN_CYC_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIN_W-1:0] win_len,
    output logic             tick
);
    localparam logic [WIN_W-1:0] DEF_LEN = WIN_W'(DEF_WIN_CYC);
    localparam logic [WIN_W-1:0] ONE     = WIN_W'(1);

    logic [WIN_W-1:0] tmr_q;
    logic [WIN_W-1:0] eff_len;

    // Pick the window length in force.
    always_comb begin
        eff_len = (win_len == '0) ? DEF_LEN : win_len;
    end

    // Last cycle of the window. ">=" also ends a window early when the length is shortened.
    always_comb begin
        tick = (tmr_q >= (eff_len - ONE));
    end

    // Advance the cycle count and restart it at each window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else if (tick) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_q + ONE;
        end
    end
endmodule

// File: rtl/wpm_pulse_acc.sv
// Saturating pulse accumulator with capture register, strobe and ready flag.
// Assumes: rise and tick are single-cycle qualifiers in the clk domain.
module wpm_pulse_acc #(
    parameter int unsigned CNT_W = wpm_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rise,
    input  logic             tick,
    input  logic             rd_ack,
    output logic [CNT_W-1:0] sample_cnt,
    output logic             sample_ovf,
    output logic             sample_stb,
    output logic             sample_rdy
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] acc_q;
    logic             ovf_run_q;

    // Running count. A pulse on the capture edge starts the next window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= '0;
            ovf_run_q <= 1'b0;
        end else if (tick) begin
            acc_q     <= rise ? CNT_ONE : '0;
            ovf_run_q <= 1'b0;
        end else if (rise) begin
            if (acc_q == CNT_MAX) begin
                ovf_run_q <= 1'b1;
            end else begin
                acc_q <= acc_q + CNT_ONE;
            end
        end
    end

    // Load the holding register and its overflow flag at the window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_cnt <= '0;
            sample_ovf <= 1'b0;
        end else if (tick) begin
            sample_cnt <= acc_q;
            sample_ovf <= ovf_run_q;
        end
    end

    // One-cycle notice of a fresh sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_stb <= 1'b0;
        end else begin
            sample_stb <= tick;
        end
    end

    // Sticky ready flag. A capture takes priority over a read acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_rdy <= 1'b0;
        end else if (tick) begin
            sample_rdy <= 1'b1;
        end else if (rd_ack) begin
            sample_rdy <= 1'b0;
        end
    end
endmodule

// File: rtl/wheel_pulse_meter.sv
// Top level: sensor synchroniser, window timer and pulse accumulator.
// Reports pulses per programmable window of system clock cycles.
// Assumes: single clock domain. sens_in may be fully asynchronous.
module wheel_pulse_meter #(
    parameter int unsigned CNT_W       = wpm_pkg::CNT_W_DEF,
    parameter int unsigned WIN_W       = wpm_pkg::WIN_W_DEF,
    parameter int unsigned SYNC_STAGES = wpm_pkg::SYNC_STAGES_DEF,
    parameter int unsigned DEF_WIN_CYC = wpm_pkg::DEF_WIN_CYC_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sens_in,
    input  logic [WIN_W-1:0] win_len,
    input  logic             rd_ack,
    output logic [CNT_W-1:0] sample_cnt,
    output logic             sample_ovf,
    output logic             sample_stb,
    output logic             sample_rdy
);
    logic rise;
    logic tick;

    wpm_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sens_in),
        .rise  (rise)
    );

    wpm_win_timer #(.WIN_W(WIN_W), .DEF_WIN_CYC(DEF_WIN_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .win_len (win_len),
        .tick    (tick)
    );

    wpm_pulse_acc #(.CNT_W(CNT_W)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise       (rise),
        .tick       (tick),
        .rd_ack     (rd_ack),
        .sample_cnt (sample_cnt),
        .sample_ovf (sample_ovf),
        .sample_stb (sample_stb),
        .sample_rdy (sample_rdy)
    );
endmodule

// File: rtl/wpm_checker.sv
// Port-level properties of wheel_pulse_meter, attached with bind.
// Assumes: observes the top-level ports only.
module wpm_checker #(
    parameter int unsigned CNT_W = wpm_pkg::CNT_W_DEF
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_ack,
    input logic [CNT_W-1:0] sample_cnt,
    input logic             sample_ovf,
    input logic             sample_stb,
    input logic             sample_rdy
);
    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sample_cnt == '0 && !sample_ovf && !sample_stb && !sample_rdy)); // R1

    AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |-> $stable(sample_cnt)); // R3

    AST_STB_SETS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> sample_rdy); // R6

    AST_RDY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_ack) && !sample_stb) |-> !sample_rdy); // R7

    AST_OVF_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        sample_ovf |-> (sample_cnt == {CNT_W{1'b1}})); // R8
endmodule

bind wheel_pulse_meter wpm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_ack     (rd_ack),
    .sample_cnt (sample_cnt),
    .sample_ovf (sample_ovf),
    .sample_stb (sample_stb),
    .sample_rdy (sample_rdy)
);

// File: tb/wheel_pulse_meter_tb.sv
// Directed bench: one task per scenario, timed against rising edges since reset release.
module wheel_pulse_meter_tb;
    localparam int unsigned CW  = 4;
    localparam int unsigned WW  = 32;
    localparam int unsigned DEF = 30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sens_in = 1'b0;
    logic [WW-1:0] win_len = '0;
    logic          rd_ack = 1'b0;
    logic [CW-1:0] sample_cnt;
    logic          sample_ovf;
    logic          sample_stb;
    logic          sample_rdy;

    int total = 0;
    int bad   = 0;
    int ecnt  = 0;

    always #5 clk = ~clk;

    // Edges since reset release. The first edge with rst_n high is edge 1.
    always @(posedge clk) begin
        if (rst_n) ecnt <= ecnt + 1;
        else       ecnt <= 0;
    end

    wheel_pulse_meter #(.CNT_W(CW), .WIN_W(WW), .DEF_WIN_CYC(DEF)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sens_in    (sens_in),
        .win_len    (win_len),
        .rd_ack     (rd_ack),
        .sample_cnt (sample_cnt),
        .sample_ovf (sample_ovf),
        .sample_stb (sample_stb),
        .sample_rdy (sample_rdy)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Return at the negedge that follows edge n.
    task automatic at_edge(input int n);
        while (ecnt < n) @(negedge clk);
    endtask

    task automatic do_reset(input int len);
        @(negedge clk);
        rst_n = 1'b0; sens_in = 1'b0; rd_ack = 1'b0; win_len = WW'(len);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // High for edges d and d+1, low from edge d+2. Counted on edge d+2.
    task automatic pulse_at(input int d);
        at_edge(d - 1); sens_in = 1'b1;
        at_edge(d + 1); sens_in = 1'b0;
    endtask

    task automatic t_basic;
        do_reset(20);
        for (int k = 0; k < 5; k++) pulse_at(1 + 4 * k);
        at_edge(19);
        chk("R6", "stb before capture", sample_stb, 0);
        chk("R3", "cnt before capture", sample_cnt, 0);
        at_edge(20);
        chk("R2", "five pulses counted", sample_cnt, 5);
        chk("R6", "stb after capture", sample_stb, 1);
        chk("R7", "rdy after capture", sample_rdy, 1);
        chk("R4", "ovf clear", sample_ovf, 0);
        at_edge(21);
        chk("R6", "stb one cycle only", sample_stb, 0);
        chk("R3", "cnt held", sample_cnt, 5);
        at_edge(40);
        chk("R3", "counter restarted", sample_cnt, 0);
        chk("R4", "second capture after win_len", sample_stb, 1);
    endtask

    task automatic t_reset;
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", "cnt in reset", sample_cnt, 0);
        chk("R1", "rdy in reset", sample_rdy, 0);
        chk("R1", "stb in reset", sample_stb, 0);
        chk("R1", "ovf in reset", sample_ovf, 0);
    endtask

    task automatic t_boundary;
        do_reset(20);
        pulse_at(14);                 // counted on edge 16
        at_edge(17); sens_in = 1'b1;  // counted on edge 20, the capture edge
        at_edge(20);
        chk("R5", "window 1 excludes boundary pulse", sample_cnt, 1);
        at_edge(40);
        chk("R5", "window 2 holds boundary pulse", sample_cnt, 1);
        at_edge(60);
        chk("R2", "held level not recounted", sample_cnt, 0);
        sens_in = 1'b0;
    endtask

    task automatic t_sat;
        do_reset(100);
        for (int k = 0; k < 17; k++) pulse_at(1 + 4 * k);
        at_edge(100);
        chk("R8", "saturated count", sample_cnt, 15);
        chk("R8", "overflow flagged", sample_ovf, 1);
        at_edge(200);
        chk("R8", "overflow cleared next window", sample_ovf, 0);
        chk("R8", "count after overflow window", sample_cnt, 0);
        do_reset(100);
        for (int k = 0; k < 15; k++) pulse_at(1 + 4 * k);
        at_edge(100);
        chk("R9", "exact max count", sample_cnt, 15);
        chk("R9", "no overflow at exact max", sample_ovf, 0);
    endtask

    task automatic t_read;
        do_reset(20);
        pulse_at(1);
        at_edge(20);
        chk("R7", "rdy set", sample_rdy, 1);
        at_edge(21); rd_ack = 1'b1;
        at_edge(22); rd_ack = 1'b0;
        chk("R7", "rdy cleared by read", sample_rdy, 0);
        chk("R7", "cnt kept by read", sample_cnt, 1);
        at_edge(39); rd_ack = 1'b1;
        at_edge(40); rd_ack = 1'b0;
        chk("R7", "capture wins over read", sample_rdy, 1);
    endtask

    task automatic t_default;
        do_reset(0);
        for (int k = 0; k < 3; k++) pulse_at(1 + 4 * k);
        at_edge(20);
        chk("R4", "no capture at 20 with default", sample_stb, 0);
        at_edge(29);
        chk("R4", "no capture at 29 with default", sample_stb, 0);
        at_edge(30);
        chk("R4", "default window capture", sample_stb, 1);
        chk("R4", "default window count", sample_cnt, 3);
    endtask

    initial begin
        t_basic();
        t_reset();
        t_boundary();
        t_sat();
        t_read();
        t_default();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule